// File: doc/BRIEF.md
# PWM Counter Event Interrupt and Trigger Unit

This unit runs one 16-bit PWM timebase and watches it for six events: the count reaching zero, the count reaching the period (load) value, and the count matching either of two compare values, A or B. Each compare match is split by count direction, so every comparator has an up-match event and a down-match event. One enable register holds two groups of six bits. The trigger group chooses which events pulse the converter-start output. The interrupt group chooses which events set sticky status bits, and those status bits drive the interrupt line.

Software reaches the unit through a word-addressed register port. Writes take effect on the clock edge. Reads are combinational. The address codes are: 0 control, 1 enable, 2 load, 3 compare A, 4 compare B, 5 status, 6 current count. Addresses 2 to 4 hold pending values. The counter adopts them when it is at zero, so a new setting never cuts into a period that is already running.

The event indices are used for both enable groups and for the status register: 0 count at zero, 1 count at load, 2 A matched counting up, 3 A matched counting down, 4 B matched counting up, 5 B matched counting down.

Top module: `pwm_evt_gen`

## Requirements
- R1: After reset every register reads zero, the count is zero, the count direction is down, and intReq and adcTrig are low.
- R2: Enable register (address 1): trigger enables sit in bits 13:8 and interrupt enables in bits 5:0, each group in event-index order from its low bit. Bits 31:14 and 7:6 read as zero and ignore writes.
- R3: With control bit 0 (run) and bit 1 (up/down) both set, the count starting from zero steps 0,1,…,L,L-1,…,1,0,1,… where L is the active load value. The direction turns around at L and at zero.
- R4: With run set and up/down clear, the count decrements by one each cycle. In the cycle after it is at zero it takes the load value, so the sequence from zero is 0,L,L-1,…,1,0. Every compare match in this mode counts as a down match.
- R5: The zero event is active in every running cycle in which the count is 0. The load event is active in every running cycle in which the count equals the active load value.
- R6: A compare event fires only when the count equals its comparator and the direction matches the event. The direction is up in the cycles from the first step above zero up to and including the cycle at L, and down otherwise. As a result, a compare value of zero or of L gives only one of its two direction events per turnaround.
- R7: adcTrig is high in exactly those cycles in which at least one event with its trigger enable set is active. It is high in the same cycle as the event, and it does not show which event caused it.
- R8: Each event whose interrupt enable is set sets its status bit (address 5, event-index order), and the bit stays set. Writing 1 to a status bit clears it, and writing 0 has no effect. A set in the same cycle wins over a clear. intReq is the OR of the status bits.
- R9: An event whose enable in a group is clear has no effect on that group's output or status bit.
- R10: Writes to load, compare A and compare B read back at once, but the counter adopts them only on a clock edge at which the count is zero.
- R11: While run is clear the count holds its value and no event is active, so adcTrig stays low and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| intReq | output | 1 | Interrupt request: OR of status bits |
| adcTrig | output | 1 | Converter start pulse: OR of trigger-enabled events |

## Verification
The assertions assume that load and compare values change only through the register port, and that the count never jumps. The count-range and shadow checks depend on this: a new load value can only reach the counter at zero. The direction check assumes the mode stays fixed while a run is in progress. The stimulus therefore programs every setting while the counter sits stopped at zero, and applies a fresh reset before each new mode. The one change made during a run is a load rewrite, and it exercises the deferred adoption.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

  localparam int NUM_EVT  = 6;
  localparam int ADDR_W   = 3;
  localparam int INT_LSB  = 0;
  localparam int TRIG_LSB = 8;

  // event indices, shared by both enable groups and the status register
  localparam int EV_ZERO = 0;
  localparam int EV_LOAD = 1;
  localparam int EV_AUP  = 2;
  localparam int EV_ADN  = 3;
  localparam int EV_BUP  = 4;
  localparam int EV_BDN  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_EN   = 3'd1,
    REG_LOAD = 3'd2,
    REG_CMPA = 3'd3,
    REG_CMPB = 3'd4,
    REG_STAT = 3'd5,
    REG_CNT  = 3'd6
  } reg_addr_e;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic run;
    logic upDown;
  } cfg_t;

endpackage

// File: rtl/pwm_evt_dp.sv
module pwm_evt_dp
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  logic [CNT_W-1:0] pendLoad,
  input  logic [CNT_W-1:0] pendCmpA,
  input  logic [CNT_W-1:0] pendCmpB,
  output logic [CNT_W-1:0] cnt,
  output logic [NUM_EVT-1:0] evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] actLoad, actCmpA, actCmpB;
  logic             dirUp;
  logic             atZero;

  assign atZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dirUp   <= 1'b0;
      actLoad <= '0;
      actCmpA <= '0;
      actCmpB <= '0;
    end else begin
      if (atZero) begin
        actLoad <= pendLoad;
        actCmpA <= pendCmpA;
        actCmpB <= pendCmpB;
      end
      if (cfg.run) begin
        if (!cfg.upDown) begin
          dirUp <= 1'b0;
          cnt   <= atZero ? pendLoad : cnt - ONE;
        end else if (dirUp) begin
          if (cnt >= actLoad) begin
            dirUp <= 1'b0;
            cnt   <= cnt - ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end else if (atZero) begin
          if (pendLoad != '0) begin
            dirUp <= 1'b1;
            cnt   <= ONE;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  always_comb begin
    evt          = '0;
    evt[EV_ZERO] = cfg.run && atZero;
    evt[EV_LOAD] = cfg.run && (cnt == actLoad);
    evt[EV_AUP]  = cfg.run && (cnt == actCmpA) &&  dirUp;
    evt[EV_ADN]  = cfg.run && (cnt == actCmpA) && !dirUp;
    evt[EV_BUP]  = cfg.run && (cnt == actCmpB) &&  dirUp;
    evt[EV_BDN]  = cfg.run && (cnt == actCmpB) && !dirUp;
  end

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> cnt <= actLoad);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && cfg.run && !cfg.upDown && $past(cfg.run && !cfg.upDown) && $past(cnt) != '0
    |-> cnt == $past(cnt) - ONE);

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $past(cnt) != '0 |-> $stable(actLoad) && $stable(actCmpA) && $stable(actCmpB));

  // R6
  dir_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && cfg.upDown && $past(cfg.run && cfg.upDown) && cnt > $past(cnt)
    |-> !evt[EV_ADN] && !evt[EV_BDN]);

endmodule

// File: rtl/pwm_evt_ctrl.sv
module pwm_evt_ctrl
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [NUM_EVT-1:0] evt,
  output cfg_t               cfg,
  output logic [CNT_W-1:0]   pendLoad,
  output logic [CNT_W-1:0]   pendCmpA,
  output logic [CNT_W-1:0]   pendCmpB,
  output logic               intReq,
  output logic               adcTrig
);

  logic               runBit, udBit;
  logic [NUM_EVT-1:0] trigEn, intEn, status, clrMask;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(busAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      udBit    <= 1'b0;
      trigEn   <= '0;
      intEn    <= '0;
      pendLoad <= '0;
      pendCmpA <= '0;
      pendCmpB <= '0;
    end else if (busWrEn) begin
      case (addr)
        REG_CTRL: begin
          runBit <= busWrData[0];
          udBit  <= busWrData[1];
        end
        REG_EN: begin
          trigEn <= busWrData[TRIG_LSB +: NUM_EVT];
          intEn  <= busWrData[INT_LSB +: NUM_EVT];
        end
        REG_LOAD: pendLoad <= busWrData[CNT_W-1:0];
        REG_CMPA: pendCmpA <= busWrData[CNT_W-1:0];
        REG_CMPB: pendCmpB <= busWrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign clrMask = (busWrEn && addr == REG_STAT) ? busWrData[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrMask) | (evt & intEn);
  end

  always_comb begin
    cfg.run    = runBit;
    cfg.upDown = udBit;
  end

  assign intReq  = |status;
  assign adcTrig = |(evt & trigEn);

  always_comb begin
    busRdData = '0;
    case (addr)
      REG_CTRL: busRdData[1:0] = {udBit, runBit};
      REG_EN: begin
        busRdData[TRIG_LSB +: NUM_EVT] = trigEn;
        busRdData[INT_LSB +: NUM_EVT]  = intEn;
      end
      REG_LOAD: busRdData[CNT_W-1:0] = pendLoad;
      REG_CMPA: busRdData[CNT_W-1:0] = pendCmpA;
      REG_CMPB: busRdData[CNT_W-1:0] = pendCmpB;
      REG_STAT: busRdData[NUM_EVT-1:0] = status;
      REG_CNT:  busRdData[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R8
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $fell(intReq) |-> $past(busWrEn && busAddr == REG_STAT));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !adcTrig);

endmodule

// File: rtl/pwm_evt_gen.sv
module pwm_evt_gen
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              intReq,
  output logic              adcTrig
);

  cfg_t               cfg;
  logic [CNT_W-1:0]   cnt, pendLoad, pendCmpA, pendCmpB;
  logic [NUM_EVT-1:0] evt;

  pwm_evt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cnt       (cnt),
    .evt       (evt),
    .cfg       (cfg),
    .pendLoad  (pendLoad),
    .pendCmpA  (pendCmpA),
    .pendCmpB  (pendCmpB),
    .intReq    (intReq),
    .adcTrig   (adcTrig)
  );

  pwm_evt_dp #(.CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .pendLoad (pendLoad),
    .pendCmpA (pendCmpA),
    .pendCmpB (pendCmpB),
    .cnt      (cnt),
    .evt      (evt)
  );

endmodule

// File: tb/test_pwm_evt_gen.sv
module test_pwm_evt_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = 3'd6;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        intReq, adcTrig;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R3";

  typedef struct packed {
    logic [15:0] cnt;
    logic        trig;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  pwm_evt_gen i_pwm_evt_gen (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .intReq(intReq), .adcTrig(adcTrig)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0; busAddr = 3'd6;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; busAddr = 3'd6;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // expected count and trigger for cycle k after run starts, from R3-style sequences
  function automatic exp_t mkExp(bit ud, int L, int A, int B, logic [5:0] en, int k);
    int c, p;
    bit up;
    logic [5:0] ev;
    exp_t e;
    if (ud) begin
      p  = k % (2 * L);
      c  = (p <= L) ? p : 2 * L - p;
      up = (p > 0) && (p <= L);
    end else begin
      p  = k % (L + 1);
      c  = (p == 0) ? 0 : L + 1 - p;
      up = 1'b0;
    end
    ev[0] = (c == 0);
    ev[1] = (c == L);
    ev[2] = (c == A) && up;
    ev[3] = (c == A) && !up;
    ev[4] = (c == B) && up;
    ev[5] = (c == B) && !up;
    e.cnt  = 16'(c);
    e.trig = |(ev & en);
    return e;
  endfunction

  task automatic runSeq(string req, bit ud, int L, int A, int B, logic [5:0] en, int n);
    doReset();
    busWrite(3'd2, 32'(L));
    busWrite(3'd3, 32'(A));
    busWrite(3'd4, 32'(B));
    busWrite(3'd1, {18'b0, en, 8'b0});
    curReq = req;
    busWrite(3'd0, {30'b0, ud, 1'b1});
    for (int k = 0; k < n; k++) expQ.push_back(mkExp(ud, L, A, B, en, k));
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        chk({curReq, " count"}, {16'b0, busRdData[15:0]}, {16'b0, e.cnt});
        chk({curReq, " R7 trigger"}, {31'b0, adcTrig}, {31'b0, e.trig});
      end
    end
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    doReset();
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      busRead(3'(a), d);
      chk("R1 register reset", d, 32'h0);
    end
    chk("R1 intReq reset", {31'b0, intReq}, 32'h0);
    chk("R1 adcTrig reset", {31'b0, adcTrig}, 32'h0);

    // R2 enable layout and reserved bits
    busWrite(3'd1, 32'hFFFF_FFFF);
    busRead(3'd1, d);
    chk("R2 enable reserved bits", d, 32'h0000_3F3F);
    busWrite(3'd1, 32'h0000_0500);
    busRead(3'd1, d);
    chk("R2 enable field placement", d, 32'h0000_0500);

    // R3 and R6: up/down, A-up trigger only, B equal to load
    runSeq("R3", 1'b1, 4, 2, 4, 6'b000100, 20);
    // R6: A at zero fires down only, B at load never down, plus load event
    runSeq("R6", 1'b1, 5, 0, 5, 6'b101010, 24);
    // R4: down-only, A down fires, A up and B up never
    runSeq("R4", 1'b0, 6, 3, 6, 6'b011100, 24);
    // R5: zero and load events
    runSeq("R5", 1'b1, 3, 7, 7, 6'b000011, 16);

    // R8 / R9: sticky status, no trigger with trigger enables clear
    doReset();
    busWrite(3'd2, 32'd3);
    busWrite(3'd3, 32'd1);
    busWrite(3'd4, 32'd2);
    busWrite(3'd1, 32'h0000_0003);
    busWrite(3'd0, 32'h3);
    d2 = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (adcTrig) d2 = 1;
    end
    chk("R9 trigger stays low with trigger enables clear", d2, 32'h0);
    busWrite(3'd0, 32'h0);
    busRead(3'd5, d);
    chk("R8 status sticky, R9 disabled events not recorded", d, 32'h3);
    chk("R8 intReq with status set", {31'b0, intReq}, 32'h1);
    busWrite(3'd5, 32'h1);
    busRead(3'd5, d);
    chk("R8 write-one clears only that bit", d, 32'h2);
    busWrite(3'd5, 32'h3C);
    busRead(3'd5, d);
    chk("R8 clearing unset bits has no effect", d, 32'h2);
    chk("R8 intReq still set", {31'b0, intReq}, 32'h1);
    busWrite(3'd5, 32'h2);
    busRead(3'd5, d);
    chk("R8 status fully cleared", d, 32'h0);
    chk("R8 intReq low after clear", {31'b0, intReq}, 32'h0);

    // R11: stopped counter holds and stays quiet
    busWrite(3'd1, 32'h0000_3F3F);
    busRead(3'd6, d);
    repeat (3) @(negedge clk);
    busRead(3'd6, d2);
    chk("R11 count holds while stopped", d2, d);
    chk("R11 no trigger while stopped", {31'b0, adcTrig}, 32'h0);
    busRead(3'd5, d);
    chk("R11 no status set while stopped", d, 32'h0);

    // R10: load rewrite adopted only at zero
    doReset();
    busWrite(3'd2, 32'd5);
    busWrite(3'd0, 32'h1);
    d = 32'hFFFF;
    for (int i = 0; i < 20 && d != 32'd3; i++) busRead(3'd6, d);
    busWrite(3'd2, 32'd2);
    busRead(3'd2, d);
    chk("R10 pending load reads back", d, 32'd2);
    d = 32'hFFFF;
    for (int i = 0; i < 20 && d != 32'd0; i++) busRead(3'd6, d);
    chk("R10 count reached zero", d, 32'd0);
    busRead(3'd6, d);
    chk("R10 reload uses new load value", d, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule